// File: doc/BRIEF.md
# SPI Slave Register Port

This block lets an external SPI master read and write a 64-entry space of 8-bit registers. The serial pins use mode-3 timing: the clock idles high, both sides change data after a falling clock edge and sample it on the rising edge. The chip-select input is active low. Pulling it low starts a transfer and releasing it ends the transfer. The serial pins are brought into the system clock domain through synchronizers. Clock edges are found by comparing the synchronized samples, so the serial clock must be several times slower than the system clock.

Every transfer opens with an 8-bit command, sent most significant bit first. The command holds a direction flag (1 writes, 0 reads), then a 6-bit register address, then a final bit that is ignored. Data bytes follow the command. After each byte the address steps up by one and wraps from 63 back to 0, so a long transfer reads or writes a run of consecutive registers. Read data goes out in the byte slots that follow the command. The `three_wire` input chooses, at run time, whether read data leaves on the dedicated output or on the shared data line.

A state machine runs the transfer. It has four states:
- IDLE: chip select is high.
- CMD: the command byte is being shifted in.
- WDATA: write bytes are being received.
- RDATA: read bytes are being sent.

It has these transitions:
- IDLE to CMD when chip select is asserted.
- CMD to WDATA or CMD to RDATA on the eighth command bit, chosen by the direction flag.
- Any state to IDLE when chip select is released.

Top module: `spi_regport`

## Requirements
- R1: After reset, `sdo`, `sdo_oe`, `sdio_o`, `sdio_oe`, `reg_we` and `reg_re` are all 0.
- R2: A write transfer of one command byte and one data byte produces exactly one single-cycle `reg_we` pulse. The pulse carries the addressed register on `reg_addr` and the received byte, MSB first, on `reg_wdata`.
- R3: The command byte is decoded as follows: bit 7 is the direction (1 = write, 0 = read), bits 6..1 are the register address, and bit 0 is ignored. Either value of bit 0 gives the same result.
- R4: In a read transfer, the addressed register value is shifted out MSB first in the byte slot after the command. Each bit changes after a falling edge of `spc` and is valid at the next rising edge.
- R5: In a transfer with several data bytes, the n-th data byte (counting from 0) goes to, or comes from, the command address plus n. This holds for both writes and reads.
- R6: During a transfer with several bytes, the address wraps from 63 to 0.
- R7: When `three_wire` is 0, read data is driven on `sdo` with `sdo_oe` high. When it is 1, read data is driven on `sdio_o` with `sdio_oe` high. The two enables are never high at the same time.
- R8: If chip select is released before a data byte is complete, that byte is not written. If chip select is released partway through a command, the next transfer still decodes its command from the first bit, because the bit count restarts on every chip-select assertion.
- R9: Both output enables are low while chip select is high, and throughout any write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| spc | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in (shared line in 3-wire mode) |
| three_wire | input | 1 | 1 = return read data on the shared line |
| sdo | output | 1 | Dedicated serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| sdio_o | output | 1 | Read data for the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| reg_addr | output | 6 | Register address |
| reg_re | output | 1 | One-cycle pulse; `reg_rdata` is sampled in this cycle |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Register read data for `reg_addr`, combinational |

## Verification
The assertions assume that `spc` and `sdi` stay stable for many system clocks between edges. They also assume that chip select changes only while `spc` is high, and that the master sends nothing on the shared line while read data is coming back. Under these assumptions, each serial edge is seen exactly once, and the address increment that follows a write strobe completes before the next edge. The stimulus holds every serial level for eight system clocks. It moves chip select only with the clock high and leaves guard time on both sides of it. It changes `three_wire` only between transfers.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA
    } rp_state_t;
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL[b]}};
            else        pipe_q <= {pipe_q[STAGES-1:0], d[b]};
        end
        assign q[b]      = pipe_q[STAGES-1];
        assign q_prev[b] = pipe_q[STAGES];
    end
endmodule

// File: rtl/spi_rp_core.sv
module spi_rp_core
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              spc_rise,
    input  logic              spc_fall,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_re,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              drv,
    output logic              tx_bit
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    rp_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-2:0] sh_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] tx_q, wdata_q;
    logic              we_q, ld_q, drv_q, bit_q;
    logic              byte_end, cmd_dir;

    assign byte_end = spc_rise && (cnt_q == LAST_BIT);
    assign cmd_dir  = sh_q[ADDR_W];

    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD:   if (byte_end) state_d = cmd_dir ? ST_WDATA : ST_RDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: state_d = ST_RDATA;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            addr_q  <= '0;
            tx_q    <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            ld_q    <= 1'b0;
            drv_q   <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            ld_q <= 1'b0;
            if (ld_q) begin
                tx_q   <= reg_rdata;
                addr_q <= addr_q + 1'b1;
            end
            if (we_q) addr_q <= addr_q + 1'b1;
            if (!cs_act) begin
                cnt_q <= '0;
                drv_q <= 1'b0;
                bit_q <= 1'b0;
            end else if (spc_rise) begin
                sh_q  <= {sh_q[DATA_W-3:0], sdi_s};
                cnt_q <= cnt_q + 1'b1;
                if (byte_end) begin
                    unique case (state_q)
                        ST_IDLE, ST_CMD: begin
                            addr_q <= sh_q[ADDR_W-1:0];
                            ld_q   <= !cmd_dir;
                        end
                        ST_WDATA: begin
                            we_q    <= 1'b1;
                            wdata_q <= {sh_q, sdi_s};
                        end
                        ST_RDATA: ld_q <= 1'b1;
                    endcase
                end
            end else if (spc_fall && state_q == ST_RDATA) begin
                bit_q <= tx_q[DATA_W-1];
                tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
                drv_q <= 1'b1;
            end
        end
    end

    assign reg_addr  = addr_q;
    assign reg_re    = ld_q;
    assign reg_we    = we_q;
    assign reg_wdata = wdata_q;
    assign drv       = drv_q;
    assign tx_bit    = bit_q;

    // R2
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |=> reg_addr == $past(reg_addr) + 1'b1);
    // R8
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(cs_act));
endmodule

// File: rtl/spi_rp_pinmux.sv
module spi_rp_pinmux (
    input  logic drv,
    input  logic tx_bit,
    input  logic three_wire,
    output logic sdo,
    output logic sdo_oe,
    output logic sdio_o,
    output logic sdio_oe
);
    assign sdo_oe  = drv && !three_wire;
    assign sdio_oe = drv && three_wire;
    assign sdo     = sdo_oe  && tx_bit;
    assign sdio_o  = sdio_oe && tx_bit;

    // R7
    one_driver_chk: assert final (!(sdo_oe && sdio_oe));
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              spc,
    input  logic              sdi,
    input  logic              three_wire,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_re,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [2:0] pin_s, pin_p;
    logic       cs_act, spc_rise, spc_fall, drv, tx_bit;

    spi_rp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, spc, sdi}), .q(pin_s), .q_prev(pin_p)
    );

    assign cs_act   = !pin_s[2];
    assign spc_rise = pin_s[1] && !pin_p[1];
    assign spc_fall = !pin_s[1] && pin_p[1];

    spi_rp_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .spc_rise(spc_rise),
        .spc_fall(spc_fall), .sdi_s(pin_s[0]), .reg_addr(reg_addr),
        .reg_re(reg_re), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .drv(drv), .tx_bit(tx_bit)
    );

    spi_rp_pinmux u_pinmux (
        .drv(drv), .tx_bit(tx_bit), .three_wire(three_wire),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> !(sdo_oe || sdio_oe));
    // R9
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !(sdo_oe || sdio_oe));
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
    localparam int HP = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, spc = 1'b1, sdi = 1'b0, three_wire = 1'b0;
    logic sdo, sdo_oe, sdio_o, sdio_oe, reg_re, reg_we;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0]  mem [64];
    logic [7:0]  exp_mem [64];
    logic [13:0] wq [$];
    int errors = 0, checks = 0, viol_oe = 0, viol_mux = 0, idle_cnt = 0;
    bit in_write = 0, done = 0;

    always #5 clk = ~clk;

    spi_regport uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .spc(spc), .sdi(sdi),
        .three_wire(three_wire), .sdo(sdo), .sdo_oe(sdo_oe), .sdio_o(sdio_o),
        .sdio_oe(sdio_oe), .reg_addr(reg_addr), .reg_re(reg_re), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    initial for (int i = 0; i < 64; i++) begin
        mem[i] = 8'(i * 7 + 3);
        exp_mem[i] = 8'(i * 7 + 3);
    end

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every write strobe pops one expected item
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wq.size() == 0) chk(0, "R8 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
                logic [13:0] e;
                e = wq.pop_front();
                chk({reg_addr, reg_wdata} == e, "R2/R5 write", {reg_addr, reg_wdata}, e);
            end
        end
        idle_cnt = cs_n ? idle_cnt + 1 : 0;
        if ((idle_cnt > 4 || in_write) && (sdo_oe || sdio_oe)) viol_oe++;
        if ((three_wire && sdo_oe) || (!three_wire && sdio_oe)) viol_mux++;
    end

    task automatic wait_hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            spc = 1'b0; sdi = b[i];
            wait_hp();
            r[i] = three_wire ? sdio_o : sdo;
            spc = 1'b1;
            wait_hp();
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0; wait_hp();
    endtask

    task automatic cs_high();
        wait_hp(); cs_n = 1'b1; wait_hp(); wait_hp();
    endtask

    task automatic do_write(input int a, input int n, input int seed, input bit dc);
        logic [7:0] r;
        in_write = 1;
        cs_low();
        spi_bits({1'b1, 6'(a), dc}, 8, r);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            logic [5:0] ad;
            d = 8'(seed + k * 29);
            ad = 6'(a + k);
            wq.push_back({ad, d});
            exp_mem[ad] = d;
            spi_bits(d, 8, r);
        end
        cs_high();
        in_write = 0;
    endtask

    task automatic do_read(input int a, input int n, input bit dc, input string req);
        logic [7:0] r;
        cs_low();
        spi_bits({1'b0, 6'(a), dc}, 8, r);
        for (int k = 0; k < n; k++) begin
            logic [5:0] ad;
            ad = 6'(a + k);
            spi_bits(8'h00, 8, r);
            chk(r == exp_mem[ad], req, r, exp_mem[ad]);
        end
        cs_high();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(sdo == 0 && sdo_oe == 0, "R1 sdo", {sdo, sdo_oe}, 0);
        chk(sdio_o == 0 && sdio_oe == 0, "R1 sdio", {sdio_o, sdio_oe}, 0);
        chk(reg_we == 0 && reg_re == 0, "R1 strobes", {reg_we, reg_re}, 0);

        // R2 single write, R4 single read
        do_write(5, 1, 8'hA5, 0);
        do_read(5, 1, 0, "R4 single read");
        do_read(9, 1, 0, "R4 untouched reg");
        // R3 ignored LSB
        do_write(12, 1, 8'h3C, 1);
        do_read(12, 1, 1, "R3 dc bit read");
        // R5 bursts
        do_write(20, 4, 8'h11, 0);
        do_read(19, 6, 0, "R5 burst read");
        // R6 wrap
        do_write(62, 3, 8'hC0, 0);
        do_read(61, 5, 0, "R6 wrap read");
        // R7 three-wire
        three_wire = 1'b1;
        wait_hp();
        do_read(20, 2, 0, "R7 3-wire read");
        three_wire = 1'b0;
        wait_hp();
        // R8 abort mid data byte
        in_write = 1;
        cs_low();
        spi_bits({1'b1, 6'd30, 1'b0}, 8, r);
        spi_bits(8'hFF, 5, r);
        cs_high();
        in_write = 0;
        do_read(30, 1, 0, "R8 aborted byte not written");
        // R8 abort mid command then clean transfer
        cs_low();
        spi_bits(8'hFF, 3, r);
        cs_high();
        do_read(5, 1, 0, "R8 counter restart");
        do_write(40, 1, 8'h77, 0);
        do_read(40, 1, 0, "R8 write after abort");

        repeat (20) @(negedge clk);
        chk(wq.size() == 0, "R2 all writes seen", wq.size(), 0);
        chk(viol_oe == 0, "R9 enables quiet", viol_oe, 0);
        chk(viol_mux == 0, "R7 enable select", viol_mux, 0);
        done = 1;
        report();
    end
endmodule